// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Binary Counter

This block is a synchronous binary counter, four bits wide by default. On every rising clock edge it loads a data word, steps up by one, steps down by one, or keeps its value. Loading is active low and takes priority over everything else. Counting needs both active-low enables to be asserted: the parallel enable and the trickle enable. A direction input chooses whether the counter steps up or down. The count wraps around at both ends.

An active-low terminal-count flag is computed combinationally from the current count, the direction and the trickle enable. The parallel enable does not take part in it. Wider counters are built by tying every stage's parallel enable to one shared enable and feeding each stage's trickle enable from the terminal-count flag of the stage below. A stage then steps only when every lower stage sits at its end value.

An asynchronous active-low reset clears the count to zero. It exists for simulation convenience only.

Top module: `udc_counter`

## Requirements
- R1: When `load_n` is 0 at a rising clock edge, `count` takes the value of `din` on that edge, whatever the enables and `up_dn` are.
- R2: When `load_n`=1, `par_en_n`=0, `trk_en_n`=0 and `up_dn`=1 at a rising edge, `count` increases by one.
- R3: When `load_n`=1, `par_en_n`=0, `trk_en_n`=0 and `up_dn`=0 at a rising edge, `count` decreases by one.
- R4: When `load_n`=1 and either `par_en_n` or `trk_en_n` is 1 at a rising edge, `count` keeps its value.
- R5: `tc_n` is 0 only when `trk_en_n` is 0 and the count equals the terminal value. In every other case it is 1.
- R6: The terminal value is all ones (15 for four bits) when `up_dn`=1, which means up, and all zeros when `up_dn`=0, which means down.
- R7: Counting wraps. Up from 14 the count runs 15, 0, 1, 2. Down from 1 it runs 0, 15, 14, 13.
- R8: `tc_n` has no register stage. It follows a change of `up_dn` or `trk_en_n` within the same clock cycle.
- R9: `par_en_n` has no effect on `tc_n`.
- R10: Two stages chained through `tc_n` into `trk_en_n`, with a shared parallel enable, count as one 8-bit counter in both directions, including across the boundary between the two nibbles.
- R11: While `rst_n` is 0 the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear (simulation aid) |
| load_n | input | 1 | Active-low synchronous parallel load |
| par_en_n | input | 1 | Active-low parallel count enable |
| trk_en_n | input | 1 | Active-low trickle count enable; also gates tc_n |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel load data |
| count | output | WIDTH | Current count |
| tc_n | output | 1 | Active-low terminal-count flag, combinational |

## Verification
The main function is driven through one sequence: a load of 13, an up run across the 15-to-0 wrap to 2, holds from each enable on its own, and a down run across the 0-to-15 wrap back to 13. This separates increment from decrement, and correct wrapping from saturation. Loads issued with both enables high and the direction reversed show that load has priority. The terminal-count flag is tested at both end values in the matching and the opposite direction, with the trickle enable high, and with only the parallel enable high. These cases tell a correctly gated flag from one keyed to the wrong enable or to the wrong end value. A two-stage chain is counted up and down across the nibble boundary, which shows whether the flag behaves correctly as a carry and borrow between stages.

// File: rtl/udc_pkg.sv
package udc_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } udc_op_e;

    typedef struct packed {
        logic [15:0] value;
    } udc_state_t;
endpackage

// File: rtl/udc_op_dec.sv
module udc_op_dec
    import udc_pkg::*;
(
    input  logic    load_n,
    input  logic    par_en_n,
    input  logic    trk_en_n,
    input  logic    up_dn,
    output udc_op_e op
);
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (par_en_n || trk_en_n)
            op = OP_HOLD;
        else if (up_dn)
            op = OP_INC;
        else
            op = OP_DEC;
    end
endmodule

// File: rtl/udc_term.sv
module udc_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             trk_en_n,
    input  logic             up_dn,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] BOT = {WIDTH{1'b0}};

    logic at_end;

    always_comb begin
        at_end = up_dn ? (cur == TOP) : (cur == BOT);
        tc_n   = !(at_end && !trk_en_n);
    end
endmodule

// File: rtl/udc_counter.sv
module udc_counter
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             par_en_n,
    input  logic             trk_en_n,
    input  logic             up_dn,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    udc_op_e          op;
    logic [WIDTH-1:0] cnt_d;
    logic [WIDTH-1:0] cnt_q;

    udc_op_dec u_dec (
        .load_n   (load_n),
        .par_en_n (par_en_n),
        .trk_en_n (trk_en_n),
        .up_dn    (up_dn),
        .op       (op)
    );

    always_comb begin
        cnt_d = cnt_q;
        case (op)
            OP_LOAD: cnt_d = din;
            OP_INC:  cnt_d = cnt_q + ONE;
            OP_DEC:  cnt_d = cnt_q - ONE;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    udc_term #(.WIDTH(WIDTH)) u_term (
        .cur      (cnt_q),
        .trk_en_n (trk_en_n),
        .up_dn    (up_dn),
        .tc_n     (tc_n)
    );

    assign count = cnt_q;

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(din));

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !par_en_n && !trk_en_n && up_dn) |=> count == $past(count) + ONE);

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !par_en_n && !trk_en_n && !up_dn) |=> count == $past(count) - ONE);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (par_en_n || trk_en_n)) |=> $stable(count));

    p_tc_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trk_en_n |-> tc_n);

    p_tc_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_en_n && up_dn && count == {WIDTH{1'b1}}) |-> !tc_n);

    p_tc_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_en_n && !up_dn && count == '0) |-> !tc_n);
endmodule

// File: tb/sim_udc_counter.sv
`timescale 1ns/1ps
module sim_udc_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1, par_en_n = 1'b1, trk_en_n = 1'b1, up_dn = 1'b1;
    logic [3:0] din = '0;
    logic [3:0] count;
    logic       tc_n;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [3:0] model = '0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    udc_counter #(.WIDTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .par_en_n(par_en_n),
        .trk_en_n(trk_en_n), .up_dn(up_dn), .din(din), .count(count), .tc_n(tc_n)
    );

    // two-stage chain for R10
    logic       c_load_n = 1'b1, c_en_n = 1'b1, c_up = 1'b1;
    logic [7:0] c_din = '0;
    logic [3:0] c_lo, c_hi;
    logic       c_tc_lo, c_tc_hi;

    udc_counter #(.WIDTH(4)) u1 (
        .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .par_en_n(c_en_n),
        .trk_en_n(c_en_n), .up_dn(c_up), .din(c_din[3:0]), .count(c_lo), .tc_n(c_tc_lo)
    );
    udc_counter #(.WIDTH(4)) u2 (
        .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .par_en_n(c_en_n),
        .trk_en_n(c_tc_lo), .up_dn(c_up), .din(c_din[7:4]), .count(c_hi), .tc_n(c_tc_hi)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // driver: apply controls at the falling edge, check the combinational flag,
    // then push the expected count for the next rising edge
    task automatic step(input string req, input logic ld, input logic pe, input logic te,
                        input logic ud, input logic [3:0] d, input logic exp_tc);
        logic at_end;
        @(negedge clk);
        load_n = ld; par_en_n = pe; trk_en_n = te; up_dn = ud; din = d;
        #1;
        at_end = ud ? (model == 4'hF) : (model == 4'h0);
        check({req, " tc_n"}, int'(tc_n), int'(exp_tc));
        check({req, " tc_n model"}, int'(tc_n), int'(!(at_end && !te)));
        if (!ld)            model = d;
        else if (pe || te)  model = model;
        else if (ud)        model = model + 4'd1;
        else                model = model - 4'd1;
        exp_q.push_back(model);
        tag_q.push_back(req);
    endtask

    // monitor: compare the count just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(count), int'(e));
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<=5000", cycles);
                finish_run();
            end
        end
    end

    task automatic cstep(input string req, input logic ld, input logic en, input logic ud,
                         input logic [7:0] d, input logic [7:0] exp8);
        @(negedge clk);
        c_load_n = ld; c_en_n = en; c_up = ud; c_din = d;
        @(posedge clk);
        #1;
        check(req, int'({c_hi, c_lo}), int'(exp8));
    endtask

    initial begin
        #22;
        check("R11 reset count", int'(count), 0);
        check("R11 reset tc_n (trk high)", int'(tc_n), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: load 13 with both enables high and down selected
        step("R1 load", 1'b0, 1'b1, 1'b1, 1'b0, 4'd13, 1'b1);
        // R2 / R7: up across the wrap
        step("R2 up 14", 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1);
        step("R2 up 15", 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1);
        // count is 15, up, trickle low: flag low (R5, R6)
        step("R7 wrap to 0", 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0);
        step("R7 up 1", 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1);
        step("R7 up 2", 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1);
        // R4: hold from each enable alone
        step("R4 hold par_en_n", 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 1'b1);
        step("R4 hold trk_en_n", 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1);
        // R3 / R7: down across the wrap to 13
        step("R3 down 1", 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1);
        step("R3 down 0", 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1);
        // count is 0, down: terminal (R6)
        step("R7 wrap to 15", 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0);
        step("R3 down 14", 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1);
        step("R3 down 13", 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1);
        // R1: load 15 with up selected and enables high
        step("R1 load 15", 1'b0, 1'b1, 1'b1, 1'b1, 4'd15, 1'b1);
        // at 15: trickle high blocks the flag (R5)
        step("R5 trk high at 15", 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b1);
        // R9: parallel enable high, trickle low, up at 15 -> flag still low
        step("R9 par high at 15", 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0);
        // R8: flip direction mid-cycle at 15 -> flag rises at once
        @(negedge clk);
        load_n = 1'b1; par_en_n = 1'b1; trk_en_n = 1'b0; up_dn = 1'b1;
        #1 check("R8 tc_n up at 15", int'(tc_n), 0);
        up_dn = 1'b0;
        #1 check("R8 tc_n after dir flip", int'(tc_n), 1);
        trk_en_n = 1'b1; up_dn = 1'b1;
        #1 check("R8 tc_n after trk rise", int'(tc_n), 1);
        // R6: load 0, down and up terminal checks
        step("R1 load 0", 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0);
        step("R6 zero down holds", 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
        step("R6 zero up not terminal", 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 1'b1);

        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        load_n = 1'b1; par_en_n = 1'b1; trk_en_n = 1'b1;

        // R10: 8-bit chain
        cstep("R10 load FE", 1'b0, 1'b1, 1'b1, 8'hFE, 8'hFE);
        cstep("R10 up FF", 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF);
        cstep("R10 up 00", 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
        cstep("R10 up 01", 1'b1, 1'b0, 1'b1, 8'h00, 8'h01);
        cstep("R10 load 10", 1'b0, 1'b1, 1'b0, 8'h10, 8'h10);
        cstep("R10 down 0F", 1'b1, 1'b0, 1'b0, 8'h00, 8'h0F);
        cstep("R10 down 0E", 1'b1, 1'b0, 1'b0, 8'h00, 8'h0E);
        cstep("R10 load 2F", 1'b0, 1'b1, 1'b1, 8'h2F, 8'h2F);
        cstep("R10 up 30", 1'b1, 1'b0, 1'b1, 8'h00, 8'h30);
        cstep("R10 hold", 1'b1, 1'b1, 1'b1, 8'h00, 8'h30);

        // R11: asynchronous clear
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R11 async clear", int'(count), 0);

        finish_run();
    end
endmodule